// File: doc/BRIEF.md
# Single-Wire Bus Bit Timing Master

This block is the bit-level timing master for a single-wire bus. The bus line is open-drain and held high by an external pull-up resistor. The block is given one of three operations: a bus reset, the sending of one bit, or the reception of one bit. It then drives the line low, releases it and samples it at fixed microsecond offsets. Each offset is converted to clock cycles through the `CLK_MHZ` parameter. When the operation is over, the block reports a completion pulse and, for a reset, whether any device answered.

A bus reset holds the line low for 490 µs and then listens for another 490 µs. The line is sampled 60 µs after release to detect a device's presence pulse. A bit slot always begins with a low pulse. A received bit is sampled 7 µs into the slot. A sent 1 releases the line at that same 7 µs point, and a sent 0 keeps the line low until the slot ends at 62 µs. Every operation closes with 2 µs of recovery before the block reports completion and becomes idle. Byte assembly, device addressing and checksums belong to the logic that issues the requests.

Top module: `ow_bit_engine`

## Requirements
- R1: After reset, busy, done, error, presence, rd_bit and bus_drive_low are all 0.
- R2: While busy is 0 the line is released (bus_drive_low = 0), and a low drive only ever begins in the cycle after a request is accepted.
- R3: A bus reset drives the line low for exactly 490·CLK_MHZ cycles, then listens for 490·CLK_MHZ cycles, then recovers for 2·CLK_MHZ cycles; busy lasts 982·CLK_MHZ cycles and ends with done.
- R4: The synchronized line is sampled 60 µs after the reset pulse is released; a low level there gives presence = 1 at completion.
- R5: A reset that finds no device still ends with done, and presence = 0.
- R6: If the synchronized line is still low 1 µs after the reset pulse is released, the operation stops at once with a one-cycle error pulse, no done, presence = 0, and a busy time of 491·CLK_MHZ cycles.
- R7: Sending a 0 holds the line low for 62·CLK_MHZ cycles; every bit slot keeps busy for 64·CLK_MHZ cycles (62 µs slot plus 2 µs recovery) and ends with done.
- R8: Sending a 1 holds the line low for 7·CLK_MHZ cycles.
- R9: Receiving a bit holds the line low for 1·CLK_MHZ cycles and samples at 7 µs; a high sample gives rd_bit = 1 and a low sample gives rd_bit = 0.
- R10: Requests that arrive while busy = 1 are ignored: they neither change the running operation nor start another one after it.
- R11: When several requests are high together in an idle cycle, reset wins over write, and write wins over read.
- R12: presence changes only when a reset ends (done or error), and rd_bit changes only when a read ends; other operations leave both unchanged.
- R13: done and error are single-cycle pulses, are never high together, and coincide with busy returning to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Request a bus reset with presence detect |
| req_write | input | 1 | Request a write slot for wr_bit |
| req_read | input | 1 | Request a read slot |
| wr_bit | input | 1 | Bit value to send, captured with req_write |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| error | output | 1 | One-cycle pulse when the line is stuck low after a reset pulse |
| presence | output | 1 | A device answered the last reset |
| rd_bit | output | 1 | Bit received by the last read slot |
| bus_drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| bus_in | input | 1 | Asynchronous line level |

## Verification
The checker tests these properties on every cycle:
- The line is never pulled low while idle, and a low drive only starts right after an accepted request.
- done and error are single-cycle pulses that never coincide.
- presence and rd_bit move only at completion.
- No busy period runs longer than a full reset sequence.

Some behaviours can only be shown by the bench's scenarios, because each needs a modelled device on the line:
- the exact length of each low pulse and each busy window;
- the value seen by the presence and read samples;
- the stuck-line error;
- request priority;
- the effect of a request made during a slot.

// File: rtl/ow_eng_pkg.sv
package ow_eng_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST_LOW,
      ST_RST_LISTEN,
      ST_SLOT,
      ST_RECOVER
   } ow_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_RESET,
      OP_WRITE,
      OP_READ
   } ow_op_e;

   // one strobe per timing point, each high in the last cycle of its interval
   typedef struct packed {
      logic release_pt;
      logic sample_pt;
      logic slot_end;
      logic recov_end;
      logic presence_pt;
      logic rst_end;
   } ow_marks_t;

   function automatic int us_to_last(input int us, input int mhz);
      return us * mhz - 1;
   endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ow_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RESET_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ow_tick_counter.sv
module ow_tick_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [WIDTH-1:0] count
);

   if (WIDTH < 1) begin : g_bad_width
      $error("ow_tick_counter: WIDTH must be positive");
   end

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (count != TOP) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/ow_mark_decode.sv
module ow_mark_decode
   import ow_eng_pkg::*;
#(
   parameter int CLK_MHZ      = 50,
   parameter int WIDTH        = 16,
   parameter int T_RELEASE_US = 1,
   parameter int T_SAMPLE_US  = 7,
   parameter int T_SLOT_US    = 62,
   parameter int T_RECOV_US   = 2,
   parameter int T_PRES_US    = 60,
   parameter int T_RST_US     = 490
) (
   input  logic [WIDTH-1:0] count,
   output ow_marks_t        marks
);

   localparam int L_RELEASE = us_to_last(T_RELEASE_US, CLK_MHZ);
   localparam int L_SAMPLE  = us_to_last(T_SAMPLE_US, CLK_MHZ);
   localparam int L_SLOT    = us_to_last(T_SLOT_US, CLK_MHZ);
   localparam int L_RECOV   = us_to_last(T_RECOV_US, CLK_MHZ);
   localparam int L_PRES    = us_to_last(T_PRES_US, CLK_MHZ);
   localparam int L_RST     = us_to_last(T_RST_US, CLK_MHZ);

   if (!(T_RELEASE_US < T_SAMPLE_US && T_SAMPLE_US < T_SLOT_US)) begin : g_bad_slot
      $error("ow_mark_decode: slot points must be strictly increasing");
   end
   if (!(T_RELEASE_US < T_PRES_US && T_PRES_US < T_RST_US)) begin : g_bad_reset
      $error("ow_mark_decode: reset points must be strictly increasing");
   end
   if (L_RST >= (1 << WIDTH) - 1 || L_SLOT >= (1 << WIDTH) - 1) begin : g_bad_width
      $error("ow_mark_decode: WIDTH too small for the longest interval");
   end

   localparam logic [WIDTH-1:0] C_RELEASE = WIDTH'(L_RELEASE);
   localparam logic [WIDTH-1:0] C_SAMPLE  = WIDTH'(L_SAMPLE);
   localparam logic [WIDTH-1:0] C_SLOT    = WIDTH'(L_SLOT);
   localparam logic [WIDTH-1:0] C_RECOV   = WIDTH'(L_RECOV);
   localparam logic [WIDTH-1:0] C_PRES    = WIDTH'(L_PRES);
   localparam logic [WIDTH-1:0] C_RST     = WIDTH'(L_RST);

   always_comb begin
      marks.release_pt  = (count == C_RELEASE);
      marks.sample_pt   = (count == C_SAMPLE);
      marks.slot_end    = (count == C_SLOT);
      marks.recov_end   = (count == C_RECOV);
      marks.presence_pt = (count == C_PRES);
      marks.rst_end     = (count == C_RST);
   end

endmodule

// File: rtl/ow_bit_engine.sv
module ow_bit_engine
   import ow_eng_pkg::*;
#(
   parameter int CLK_MHZ     = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_reset,
   input  logic req_write,
   input  logic req_read,
   input  logic wr_bit,
   output logic busy,
   output logic done,
   output logic error,
   output logic presence,
   output logic rd_bit,
   output logic bus_drive_low,
   input  logic bus_in
);

   localparam int LONGEST = 490 * CLK_MHZ;
   localparam int CW      = $clog2(LONGEST + 2);

   // the stuck-line check at 1 us must see the released level through the synchronizer
   if (CLK_MHZ < SYNC_STAGES + 1) begin : g_bad_clk
      $error("ow_bit_engine: CLK_MHZ must exceed SYNC_STAGES");
   end

   ow_state_e state_q, state_d;
   ow_op_e    op_q, op_d;
   logic      wv_q, wv_d;
   logic      drv_q, drv_d;
   logic      done_q, done_d;
   logic      err_q, err_d;
   logic      pres_q, pres_d;
   logic      rd_q, rd_d;
   logic      ptmp_q, ptmp_d;
   logic      rtmp_q, rtmp_d;
   logic      line_s;
   logic      phase_chg;
   logic [CW-1:0] cnt;
   ow_marks_t mk;

   ow_line_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(bus_in),
      .sync_out(line_s)
   );

   ow_tick_counter #(
      .WIDTH(CW)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(phase_chg),
      .count(cnt)
   );

   ow_mark_decode #(
      .CLK_MHZ(CLK_MHZ),
      .WIDTH  (CW)
   ) u_marks (
      .count(cnt),
      .marks(mk)
   );

   assign phase_chg = (state_d != state_q);

   always_comb begin
      state_d = state_q;
      op_d    = op_q;
      wv_d    = wv_q;
      drv_d   = drv_q;
      done_d  = 1'b0;
      err_d   = 1'b0;
      pres_d  = pres_q;
      rd_d    = rd_q;
      ptmp_d  = ptmp_q;
      rtmp_d  = rtmp_q;
      unique case (state_q)
         ST_IDLE: begin
            drv_d = 1'b0;
            if (req_reset) begin
               state_d = ST_RST_LOW;
               op_d    = OP_RESET;
               drv_d   = 1'b1;
               ptmp_d  = 1'b0;
            end else if (req_write) begin
               state_d = ST_SLOT;
               op_d    = OP_WRITE;
               wv_d    = wr_bit;
               drv_d   = 1'b1;
            end else if (req_read) begin
               state_d = ST_SLOT;
               op_d    = OP_READ;
               drv_d   = 1'b1;
               rtmp_d  = 1'b0;
            end
         end
         ST_RST_LOW: begin
            if (mk.rst_end) begin
               state_d = ST_RST_LISTEN;
               drv_d   = 1'b0;
            end
         end
         ST_RST_LISTEN: begin
            if (mk.release_pt && !line_s) begin
               state_d = ST_IDLE;
               op_d    = OP_NONE;
               err_d   = 1'b1;
               pres_d  = 1'b0;
            end else begin
               if (mk.presence_pt) begin
                  ptmp_d = !line_s;
               end
               if (mk.rst_end) begin
                  state_d = ST_RECOVER;
               end
            end
         end
         ST_SLOT: begin
            if (mk.release_pt && op_q == OP_READ) begin
               drv_d = 1'b0;
            end
            if (mk.sample_pt) begin
               if (op_q == OP_READ) begin
                  rtmp_d = line_s;
               end else begin
                  drv_d = !wv_q;
               end
            end
            if (mk.slot_end) begin
               state_d = ST_RECOVER;
               drv_d   = 1'b0;
            end
         end
         ST_RECOVER: begin
            drv_d = 1'b0;
            if (mk.recov_end) begin
               state_d = ST_IDLE;
               op_d    = OP_NONE;
               done_d  = 1'b1;
               if (op_q == OP_RESET) begin
                  pres_d = ptmp_q;
               end
               if (op_q == OP_READ) begin
                  rd_d = rtmp_q;
               end
            end
         end
         default: begin
            state_d = ST_IDLE;
            op_d    = OP_NONE;
            drv_d   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_NONE;
         wv_q    <= 1'b0;
         drv_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         pres_q  <= 1'b0;
         rd_q    <= 1'b0;
         ptmp_q  <= 1'b0;
         rtmp_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         op_q    <= op_d;
         wv_q    <= wv_d;
         drv_q   <= drv_d;
         done_q  <= done_d;
         err_q   <= err_d;
         pres_q  <= pres_d;
         rd_q    <= rd_d;
         ptmp_q  <= ptmp_d;
         rtmp_q  <= rtmp_d;
      end
   end

   assign busy          = (state_q != ST_IDLE);
   assign done          = done_q;
   assign error         = err_q;
   assign presence      = pres_q;
   assign rd_bit        = rd_q;
   assign bus_drive_low = drv_q;

endmodule

// File: rtl/ow_bit_engine_chk.sv
module ow_bit_engine_chk #(
   parameter int CLK_MHZ = 50
) (
   input logic clk,
   input logic rst_n,
   input logic req_reset,
   input logic req_write,
   input logic req_read,
   input logic busy,
   input logic done,
   input logic error,
   input logic presence,
   input logic rd_bit,
   input logic bus_drive_low
);

   localparam int MAX_BUSY = 982 * CLK_MHZ;

   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_len <= 0;
      end else if (busy) begin
         busy_len <= busy_len + 1;
      end else begin
         busy_len <= 0;
      end
   end

   // R2
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_drive_low);

   // R2
   drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive_low) |-> $rose(busy));

   // R3
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (req_reset || req_write || req_read)) |=> (busy && bus_drive_low));

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R13
   error_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error);

   // R13
   exclusive_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> (!busy && !(done && error)));

   // R13
   end_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> $past(busy));

   // R12
   presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (presence != $past(presence)) |-> (done || error));

   // R12
   rdbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_bit != $past(rd_bit)) |-> done);

   // R3
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_len <= MAX_BUSY);

endmodule

bind ow_bit_engine ow_bit_engine_chk #(
   .CLK_MHZ(CLK_MHZ)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_reset    (req_reset),
   .req_write    (req_write),
   .req_read     (req_read),
   .busy         (busy),
   .done         (done),
   .error        (error),
   .presence     (presence),
   .rd_bit       (rd_bit),
   .bus_drive_low(bus_drive_low)
);

// File: tb/ow_bit_engine_test.sv
module ow_bit_engine_test;

   localparam int M = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_reset = 1'b0, req_write = 1'b0, req_read = 1'b0, wr_bit = 1'b0;
   logic busy, done, error, presence, rd_bit, bus_drive_low, bus_in;

   int n_chk = 0;
   int n_err = 0;

   // device model: 0 none, 1 presence pulse, 2 stuck low, 3 answers a read with 0
   int   dev_mode = 0;
   int   since_rise = 100000;
   int   since_fall = 100000;
   logic drv_prev = 1'b0;
   logic dev_pull;

   always #2 clk = ~clk;

   ow_bit_engine #(.CLK_MHZ(M)) uut (
      .clk(clk), .rst_n(rst_n), .req_reset(req_reset), .req_write(req_write),
      .req_read(req_read), .wr_bit(wr_bit), .busy(busy), .done(done),
      .error(error), .presence(presence), .rd_bit(rd_bit),
      .bus_drive_low(bus_drive_low), .bus_in(bus_in)
   );

   always @(posedge clk) begin
      drv_prev <= bus_drive_low;
      if (bus_drive_low && !drv_prev) since_rise <= 0;
      else if (since_rise < 100000) since_rise <= since_rise + 1;
      if (!bus_drive_low && drv_prev) since_fall <= 0;
      else if (since_fall < 100000) since_fall <= since_fall + 1;
   end

   always_comb begin
      case (dev_mode)
         1: dev_pull = (since_fall >= 20 * M) && (since_fall < 150 * M);
         2: dev_pull = 1'b1;
         3: dev_pull = (since_rise < 30 * M);
         default: dev_pull = 1'b0;
      endcase
   end

   assign bus_in = !(bus_drive_low || dev_pull);

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // kind: 0 reset, 1 write, 2 read, 3 all three at once, 4 write and read at once
   task automatic run_op(input int kind, input bit wb, input int inject_at,
                         output int bc, output int lc, output int dn, output int er);
      bc = 0; lc = 0; dn = 0; er = 0;
      @(negedge clk);
      wr_bit    = wb;
      req_reset = (kind == 0 || kind == 3);
      req_write = (kind == 1 || kind == 3 || kind == 4);
      req_read  = (kind == 2 || kind == 3 || kind == 4);
      @(negedge clk);
      req_reset = 1'b0; req_write = 1'b0; req_read = 1'b0;
      for (int i = 0; i < 6000; i++) begin
         if (!busy) begin
            dn = done; er = error;
            break;
         end
         bc++;
         if (bus_drive_low) lc++;
         if (bc == inject_at) begin
            req_read = 1'b1; req_reset = 1'b1;
         end else begin
            req_read = 1'b0; req_reset = 1'b0;
         end
         @(negedge clk);
      end
      req_read = 1'b0; req_reset = 1'b0;
   endtask

   task automatic t_reset_state;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 error", error, 0);
      chk("R1 presence", presence, 0);
      chk("R1 rd_bit", rd_bit, 0);
      chk("R1 R2 drive", bus_drive_low, 0);
   endtask

   task automatic t_reset_present;
      int bc, lc, dn, er;
      dev_mode = 1;
      run_op(0, 1'b0, -1, bc, lc, dn, er);
      dev_mode = 0;
      chk("R3 low length", lc, 490 * M);
      chk("R3 busy length", bc, 982 * M);
      chk("R3 done", dn, 1);
      chk("R4 presence", presence, 1);
      @(negedge clk);
      chk("R13 done single", done, 0);
   endtask

   task automatic t_reset_stuck;
      int bc, lc, dn, er;
      dev_mode = 2;
      run_op(0, 1'b0, -1, bc, lc, dn, er);
      dev_mode = 0;
      chk("R6 error", er, 1);
      chk("R6 no done", dn, 0);
      chk("R6 busy length", bc, 491 * M);
      chk("R6 presence", presence, 0);
      @(negedge clk);
      chk("R13 error single", error, 0);
   endtask

   task automatic t_reset_absent;
      int bc, lc, dn, er;
      dev_mode = 1;
      run_op(0, 1'b0, -1, bc, lc, dn, er);
      dev_mode = 0;
      chk("R4 presence set", presence, 1);
      run_op(0, 1'b0, -1, bc, lc, dn, er);
      chk("R5 done", dn, 1);
      chk("R5 no error", er, 0);
      chk("R5 presence", presence, 0);
   endtask

   task automatic t_write;
      int bc, lc, dn, er;
      run_op(1, 1'b0, -1, bc, lc, dn, er);
      chk("R7 low length", lc, 62 * M);
      chk("R7 busy length", bc, 64 * M);
      chk("R7 done", dn, 1);
      run_op(1, 1'b1, -1, bc, lc, dn, er);
      chk("R8 low length", lc, 7 * M);
      chk("R8 busy length", bc, 64 * M);
   endtask

   task automatic t_read;
      int bc, lc, dn, er;
      run_op(2, 1'b0, -1, bc, lc, dn, er);
      chk("R9 low length", lc, M);
      chk("R9 read one", rd_bit, 1);
      chk("R9 done", dn, 1);
      dev_mode = 3;
      run_op(2, 1'b0, -1, bc, lc, dn, er);
      dev_mode = 0;
      chk("R9 read zero", rd_bit, 0);
      chk("R12 presence kept by read", presence, 0);
   endtask

   task automatic t_ignored;
      int bc, lc, dn, er;
      run_op(1, 1'b1, 100, bc, lc, dn, er);
      chk("R10 low length", lc, 7 * M);
      chk("R10 busy length", bc, 64 * M);
      repeat (10) begin
         @(negedge clk);
         chk("R10 no later op", busy, 0);
      end
      chk("R12 rd_bit kept by write", rd_bit, 0);
      chk("R12 presence kept by write", presence, 0);
   endtask

   task automatic t_priority;
      int bc, lc, dn, er;
      run_op(3, 1'b0, -1, bc, lc, dn, er);
      chk("R11 reset wins low", lc, 490 * M);
      chk("R11 reset wins busy", bc, 982 * M);
      run_op(4, 1'b0, -1, bc, lc, dn, er);
      chk("R11 write wins low", lc, 62 * M);
      chk("R11 rd_bit untouched", rd_bit, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset_present();
      t_reset_stuck();
      t_reset_absent();
      t_write();
      t_read();
      t_ignored();
      t_priority();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired before the scenarios completed");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule